// File: doc/BRIEF.md
# Sixteen-Line GPIO Port with Per-Pin Interrupt Detection

This block is a 16-pin general-purpose I/O port behind a plain 32-bit register port. Software sets an output value and a direction mask, and reads the pin levels after a two-flop synchronizer. Every pin has a 3-bit detection style: high level, low level, rising edge, falling edge, either edge, or no detection. A detected condition sets a sticky status bit. The status vector goes straight out as a per-pin interrupt request for an interrupt controller.

Status bits are cleared by writing ones. A bit with a level style cannot be cleared while its condition is still on the pin. A clock-control word is kept and can be read back, but it has no effect on the pins. The debounce-select word reads as zero. The register port has no back-pressure. A write takes effect at the rising edge where `reg_valid` and `reg_write` are both high. Read data follows `reg_addr` combinationally.

Top module: `gpio16_port`

## Requirements
- R1: After reset, the output word is 0, the direction word is 0xFFFF (every pin an input, so `pin_oe` is 0), all style, clock and status words are 0, and `irq` is 0.
- R2: Word 0x00 holds the output value. Its low 16 bits drive `pin_out`, and bits 31:16 read as 0.
- R3: Word 0x04 holds the direction. A 1 in bit i makes pin i an input (`pin_oe[i]`=0), and a 0 lets the output value drive it (`pin_oe[i]`=1).
- R4: Word 0x08 returns the synchronized pin levels. A pin change becomes readable after two rising clock edges. Writes to this word are ignored.
- R5: Each pin has a 3-bit style field. Pins 0 to 7 use word 0x10 at bit 3*i. Pins 8 to 15 use word 0x14 at bit 3*(i-8). Bits 31:24 of both words read as 0.
- R6: Style 2 (rising), 3 (falling) and 4 (either) set the status bit on the matching change of the synchronized level. The bit is set at the third rising edge after the pin change.
- R7: Style 0 (high) and 1 (low) set the status bit on every cycle the synchronized level matches. A clear written while the level still matches leaves the bit set.
- R8: Style codes 5, 6 and 7 never set status.
- R9: Word 0x0C reads the status. Writing a 1 to bit i clears it, and writing a 0 leaves it unchanged. A bit otherwise holds, and `irq` equals the status.
- R10: Word 0x18 stores and returns all 32 bits and has no effect on `pin_out` or `pin_oe`. Word 0x1C always reads 0 and ignores writes.
- R11: Only word-aligned accesses act. A write whose `reg_addr[1:0]` is not 0 changes nothing, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Byte address of the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output values to the pads |
| pin_oe | output | 16 | Per-pin output enable, 1 = drive |
| irq | output | 16 | Per-pin interrupt request |

## Verification
A wrong synchronizer or edge history shows up on `irq` one cycle too early or too late. It can also show as an edge event that never arrives, or one that arrives on the wrong polarity. The bench checks `irq` at the exact edge on which it should rise. A stuck status or clear path is visible at the next read of word 0x0C: a level bit that drops while its condition holds, or an edge bit that survives a clear. A misplaced style field moves the detection onto a neighbouring pin within three cycles of the next pin change.

// File: rtl/gpio16_pkg.sv
package gpio16_pkg;
  localparam int REG_W   = 32;
  localparam int STYLE_W = 3;

  localparam logic [STYLE_W-1:0] ST_HIGH = 3'd0;
  localparam logic [STYLE_W-1:0] ST_LOW  = 3'd1;
  localparam logic [STYLE_W-1:0] ST_RISE = 3'd2;
  localparam logic [STYLE_W-1:0] ST_FALL = 3'd3;
  localparam logic [STYLE_W-1:0] ST_ANY  = 3'd4;

  typedef enum logic [2:0] {
    W_OUT    = 3'd0,
    W_DIR    = 3'd1,
    W_IN     = 3'd2,
    W_STS    = 3'd3,
    W_TYP_LO = 3'd4,
    W_TYP_HI = 3'd5,
    W_CLK    = 3'd6,
    W_DBNC   = 3'd7
  } word_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta   <= '0;
      q      <= '0;
      q_prev <= '0;
    end else begin
      meta   <= d;
      q      <= meta;
      q_prev <= q;
    end
  end
endmodule

// File: rtl/gpio_pin_event.sv
module gpio_pin_event
  import gpio16_pkg::*;
(
  input  logic [STYLE_W-1:0] style,
  input  logic               cur,
  input  logic               prev,
  output logic               hit
);
  always_comb begin
    case (style)
      ST_HIGH: hit = cur;
      ST_LOW:  hit = ~cur;
      ST_RISE: hit = cur & ~prev;
      ST_FALL: hit = ~cur & prev;
      ST_ANY:  hit = cur ^ prev;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio16_port.sv
module gpio16_port
  import gpio16_pkg::*;
#(
  parameter int NUM_PINS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_valid,
  input  logic                reg_write,
  input  logic [4:0]          reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] irq
);
  localparam int HALF   = NUM_PINS / 2;
  localparam int TYPE_W = HALF * STYLE_W;

  logic [NUM_PINS-1:0] out_q, dir_q, sts_q, clr_vec, hit_vec;
  logic [NUM_PINS-1:0] sync_cur, sync_prev;
  logic [TYPE_W-1:0]   typ_lo_q, typ_hi_q;
  logic [REG_W-1:0]    clk_q;
  logic [2*TYPE_W-1:0] style_flat;
  logic                aligned, wr_en;
  word_e               word;

  assign aligned    = (reg_addr[1:0] == 2'b00);
  assign word       = word_e'(reg_addr[4:2]);
  assign wr_en      = reg_valid & reg_write & aligned;
  assign style_flat = {typ_hi_q, typ_lo_q};
  assign clr_vec    = (wr_en && word == W_STS) ? reg_wdata[NUM_PINS-1:0] : '0;

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      (pin_in),
    .q      (sync_cur),
    .q_prev (sync_prev)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [STYLE_W-1:0] style_i;
    assign style_i = style_flat[STYLE_W*i +: STYLE_W];

    gpio_pin_event u_evt (
      .style (style_i),
      .cur   (sync_cur[i]),
      .prev  (sync_prev[i]),
      .hit   (hit_vec[i])
    );

    assert_rise_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (style_i == ST_RISE && $rose(sync_cur[i])) |=> sts_q[i]);
    assert_fall_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (style_i == ST_FALL && $fell(sync_cur[i])) |=> sts_q[i]);
    assert_level_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (style_i == ST_HIGH && sync_cur[i]) |=> sts_q[i]);
    assert_level_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (style_i == ST_LOW && !sync_cur[i]) |=> sts_q[i]);
    assert_no_detect_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (style_i > ST_ANY && !sts_q[i]) |=> !sts_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '1;
      typ_lo_q <= '0;
      typ_hi_q <= '0;
      clk_q    <= '0;
      sts_q    <= '0;
    end else begin
      sts_q <= (sts_q & ~clr_vec) | hit_vec;
      if (wr_en) begin
        case (word)
          W_OUT:    out_q    <= reg_wdata[NUM_PINS-1:0];
          W_DIR:    dir_q    <= reg_wdata[NUM_PINS-1:0];
          W_TYP_LO: typ_lo_q <= reg_wdata[TYPE_W-1:0];
          W_TYP_HI: typ_hi_q <= reg_wdata[TYPE_W-1:0];
          W_CLK:    clk_q    <= reg_wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      case (word)
        W_OUT:    reg_rdata[NUM_PINS-1:0] = out_q;
        W_DIR:    reg_rdata[NUM_PINS-1:0] = dir_q;
        W_IN:     reg_rdata[NUM_PINS-1:0] = sync_cur;
        W_STS:    reg_rdata[NUM_PINS-1:0] = sts_q;
        W_TYP_LO: reg_rdata[TYPE_W-1:0]   = typ_lo_q;
        W_TYP_HI: reg_rdata[TYPE_W-1:0]   = typ_hi_q;
        W_CLK:    reg_rdata               = clk_q;
        default:  reg_rdata               = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = ~dir_q;
  assign irq     = sts_q;

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(sts_q) & ~$past(clr_vec)) & ~sts_q) == '0));
  assert_dir_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && irq == '0));
endmodule

// File: tb/tb_gpio16_port.sv
module tb_gpio16_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  gpio16_port dut (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {byte address, write data, expected read-back}; covers R2 R3 R4 R5 R10
  localparam int NVEC = 7;
  localparam logic [68:0] VEC [NVEC] = '{
    {5'h00, 32'hFFFF_A5C3, 32'h0000_A5C3},
    {5'h04, 32'h1234_00FF, 32'h0000_00FF},
    {5'h10, 32'hFFFF_FFFF, 32'h00FF_FFFF},
    {5'h14, 32'hAB12_3456, 32'h0012_3456},
    {5'h18, 32'h1234_5678, 32'h1234_5678},
    {5'h1C, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h08, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
    chk("R1 pin_out", {16'h0, pin_out}, 32'h0);
    chk("R1 irq", {16'h0, irq}, 32'h0);
    rd(5'h04, rv); chk("R1 dir word", rv, 32'h0000_FFFF);
    rd(5'h10, rv); chk("R1 style word", rv, 32'h0);
    rd(5'h0C, rv); chk("R1 status word", rv, 32'h0);

    // register vector table
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][68:64], VEC[k][63:32]);
      rd(VEC[k][68:64], rv);
      chk($sformatf("R2 R3 R4 R5 R10 table row %0d", k), rv, VEC[k][31:0]);
    end
    chk("R2 pin_out", {16'h0, pin_out}, 32'h0000_A5C3);
    chk("R3 pin_oe (R10 clock word no effect)", {16'h0, pin_oe}, 32'h0000_FF00);

    // R11 misaligned write ignored, misaligned read zero
    wr(5'h01, 32'h0);
    chk("R11 misaligned write", {16'h0, pin_out}, 32'h0000_A5C3);
    rd(5'h01, rv); chk("R11 misaligned read", rv, 32'h0);

    // styles: p0 high, p1 low, p2 rise, p3 fall, p4 any, p5 code5, p6 code7, p9 rise
    wr(5'h10, 32'h001E_C688);
    wr(5'h14, 32'h0000_0010);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, rv); chk("R7 low-level re-asserts after clear", rv, 32'h0000_0002);
    wr(5'h0C, 32'h0000_0002);
    rd(5'h0C, rv); chk("R7 clear while low held", rv, 32'h0000_0002);

    // phase B: p1 high, p2 rises, p5 rises (code 5)
    drive(16'h0026); settle();
    rd(5'h0C, rv); chk("R6 rise, R8 code5 silent", rv, 32'h0000_0006);
    wr(5'h0C, 32'h0000_FFFF);
    rd(5'h0C, rv); chk("R9 clear ones", rv, 32'h0);

    // phase C: p0 high, p3 rise (fall style), p4 any, p6 code7, p9 rise; latency
    drive(16'h027F);
    @(negedge clk); @(negedge clk);
    chk("R6 not before third edge", {31'h0, irq[4]}, 32'h0);
    rd(5'h08, rv); chk("R4 sync after two edges", rv, 32'h0000_027F);
    @(negedge clk);
    chk("R6 set at third edge", {16'h0, irq}, 32'h0000_0211);
    @(negedge clk);
    rd(5'h0C, rv); chk("R6 R7 R8 mixed styles", rv, 32'h0000_0211);
    wr(5'h0C, 32'h0000_FFFF);
    rd(5'h0C, rv); chk("R7 high level survives clear", rv, 32'h0000_0001);

    // phase D: p0 low, p3 falls
    drive(16'h0276); settle();
    rd(5'h0C, rv); chk("R6 fall plus R9 held bit", rv, 32'h0000_0009);
    chk("R9 irq equals status", {16'h0, irq}, 32'h0000_0009);
    wr(5'h0C, 32'h0000_FFFF);
    rd(5'h0C, rv); chk("R9 clear after level gone", rv, 32'h0);

    // phase E: p4 falls (any transition)
    drive(16'h0266); settle();
    rd(5'h0C, rv); chk("R6 either edge on fall", rv, 32'h0000_0010);
    wr(5'h0C, 32'h0);
    rd(5'h0C, rv); chk("R9 zero write no effect", rv, 32'h0000_0010);
    wr(5'h0C, 32'h0000_FFEF);
    rd(5'h0C, rv); chk("R9 other bits written", rv, 32'h0000_0010);
    wr(5'h0C, 32'h0000_0010);
    rd(5'h0C, rv); chk("R9 single bit clear", rv, 32'h0);
    wr(5'h08, 32'h0);
    rd(5'h08, rv); chk("R4 input word write ignored", rv, 32'h0000_0266);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule